// File: doc/BRIEF.md
# Debug Halt Entry and Resume Controller

This block is the control state machine that takes a small 32-bit core into external debug mode and brings it back out. It watches a level-sensitive halt request, the decoded breakpoint, debug-return and wait-for-interrupt instructions, an exception flag, the current privilege level and an instruction-retire strobe. It keeps the debug control bits (single step, breakpoint-to-debug for machine and user mode) and the captured resume context: entry reason, prior privilege and resume PC. From these it drives a fetch redirect, an interrupt-accept gate, a "treat this wait as a no-op" override, an illegal-instruction flag and a trap-register write enable.

The controller has four states. RUN is normal execution. SLEEP is a core that is halted by a wait-for-interrupt. DEBUG is execution inside the debug program. STEP is normal execution armed to re-halt after one instruction. The transitions are: RUN to SLEEP on a wait instruction; SLEEP to RUN on a pending interrupt; RUN, SLEEP or STEP to DEBUG on an entry event (halt request, a breakpoint routed to debug, or a retire while in STEP); DEBUG to RUN on a debug return with stepping off; DEBUG to STEP on a debug return with stepping on. Inside DEBUG, a breakpoint or an exception redirects fetch but keeps the state. Entry is decided in the cycle of the event. The redirect for it is combinational, and the state and captured context update at the following clock edge.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: In RUN or STEP with no exception, a high `halt_req_i` drives `redir_o`=1 with `redir_pc_o`=ROM_ENTRY in that cycle. From the next cycle `in_dbg_o`=1, `dpc_o` holds that cycle's `next_pc_i`, `cause_o`=3 and `saved_prv_o` holds `cur_prv_i` (3 = machine, 0 = user).
- R2: A wait instruction (`wfi_i`) in RUN sets `sleep_o` from the next cycle. In SLEEP, a halt request enters debug and clears `sleep_o`. In SLEEP, a pending interrupt raises `irq_take_o` and returns to RUN.
- R3: `irq_take_o` is 0 whenever `in_dbg_o`=1. In a cycle where a debug entry happens, `irq_take_o` is 0 even with `irq_pend_i` high.
- R4: `wfi_i` in DEBUG raises `wfi_nop_o` and gives no redirect. The controller stays in DEBUG and `sleep_o` stays 0.
- R5: `ret_i` outside DEBUG raises `illegal_o`, gives no redirect and leaves the state unchanged.
- R6: `brk_i` in DEBUG redirects to ROM_ENTRY and keeps DEBUG. `dpc_o` and `cause_o` stay unchanged.
- R7: Outside DEBUG, `brk_i` enters debug with `cause_o`=1 and `dpc_o`=`inst_pc_i` when privilege 3 has the machine break bit set, or privilege 0 has the user break bit set. Otherwise it raises `brk_exc_o` and gives no redirect.
- R8: `ret_i` in DEBUG redirects to `dpc_o` and leaves DEBUG. `saved_prv_o` holds the privilege to restore.
- R9: After a debug return with the step bit set, no entry happens until `retire_i`. In the retire cycle the controller redirects to ROM_ENTRY and then shows `cause_o`=4 and `dpc_o`=`next_pc_i`.
- R10: `exc_i` in DEBUG keeps `trap_wr_o`=0, redirects to ROM_EXC and stays in DEBUG. Outside DEBUG, `exc_i` raises `trap_wr_o`.
- R11: `ctl_we_i` updates the step and break bits only in DEBUG. Outside DEBUG the write is dropped.
- R12: When entry reasons coincide, the recorded cause follows the priority breakpoint (1) over halt request (3) over step (4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req_i | input | 1 | External debug halt request (level) |
| brk_i | input | 1 | Breakpoint instruction in execute |
| ret_i | input | 1 | Debug-return instruction in execute |
| wfi_i | input | 1 | Wait-for-interrupt instruction in execute |
| exc_i | input | 1 | Current instruction raises an exception |
| retire_i | input | 1 | Instruction retires this cycle |
| irq_pend_i | input | 1 | An enabled interrupt is pending |
| cur_prv_i | input | 2 | Current privilege (3 machine, 0 user) |
| inst_pc_i | input | XLEN | PC of the instruction in execute |
| next_pc_i | input | XLEN | PC of the next instruction to run |
| ctl_we_i | input | 1 | Write strobe for debug control bits |
| ctl_step_i | input | 1 | New single-step bit |
| ctl_brkm_i | input | 1 | New machine-mode break-to-debug bit |
| ctl_brku_i | input | 1 | New user-mode break-to-debug bit |
| in_dbg_o | output | 1 | Core is in debug mode |
| sleep_o | output | 1 | Core sleeps in wait-for-interrupt |
| redir_o | output | 1 | Fetch redirect valid |
| redir_pc_o | output | XLEN | Fetch redirect target |
| irq_take_o | output | 1 | Interrupt may be taken this cycle |
| wfi_nop_o | output | 1 | Treat the wait instruction as a no-op |
| illegal_o | output | 1 | Debug return is illegal here |
| brk_exc_o | output | 1 | Raise a breakpoint exception |
| trap_wr_o | output | 1 | Trap registers may be written |
| cause_o | output | 3 | Recorded entry reason |
| saved_prv_o | output | 2 | Privilege captured on entry |
| dpc_o | output | XLEN | Captured resume PC |

## Verification
Debug entry and interrupt acceptance can land in the same cycle. The bench raises `irq_pend_i` together with a halt request in RUN, and expects the redirect with `irq_take_o` low. The same pairing is checked on a wake from SLEEP. The halt request and a routed breakpoint can also arrive together. The bench drives both at once and judges the outcome by the recorded cause and resume PC, which must be the breakpoint's and not the request's.

// File: rtl/dbg_mode_pkg.sv
package dbg_mode_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_DEBUG = 2'd2,
        ST_STEP  = 2'd3
    } dbg_state_e;

    localparam logic [2:0] CAUSE_NONE = 3'd0;
    localparam logic [2:0] CAUSE_BRK  = 3'd1;
    localparam logic [2:0] CAUSE_REQ  = 3'd3;
    localparam logic [2:0] CAUSE_STEP = 3'd4;

    localparam logic [1:0] PRV_USER    = 2'd0;
    localparam logic [1:0] PRV_MACHINE = 2'd3;

endpackage

// File: rtl/dbg_entry_arb.sv
module dbg_entry_arb
    import dbg_mode_pkg::*;
(
    input  dbg_state_e  state,
    input  logic        halt_req_i,
    input  logic        brk_i,
    input  logic        exc_i,
    input  logic        retire_i,
    input  logic [1:0]  cur_prv_i,
    input  logic        brkm,
    input  logic        brku,
    output logic        brk_route,
    output logic        enter,
    output logic [2:0]  cause,
    output logic        use_inst_pc
);
    logic executing;
    logic can_enter;
    logic e_brk;
    logic e_req;
    logic e_step;

    always_comb begin
        executing = (state == ST_RUN) || (state == ST_STEP);
        can_enter = (state != ST_DEBUG) && !exc_i;
        brk_route = brk_i && (((cur_prv_i == PRV_MACHINE) && brkm) ||
                              ((cur_prv_i == PRV_USER) && brku));
        e_brk  = can_enter && executing && brk_route;
        e_req  = can_enter && halt_req_i;
        e_step = can_enter && (state == ST_STEP) && retire_i;
        enter  = e_brk || e_req || e_step;
        use_inst_pc = e_brk;
        if (e_brk)       cause = CAUSE_BRK;
        else if (e_req)  cause = CAUSE_REQ;
        else if (e_step) cause = CAUSE_STEP;
        else             cause = CAUSE_NONE;
    end
endmodule

// File: rtl/dbg_csr_file.sv
module dbg_csr_file
    import dbg_mode_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr,
    input  logic            ctl_step_i,
    input  logic            ctl_brkm_i,
    input  logic            ctl_brku_i,
    input  logic            capture,
    input  logic [2:0]      cause_i,
    input  logic [1:0]      prv_i,
    input  logic [XLEN-1:0] pc_i,
    output logic            step_q,
    output logic            brkm_q,
    output logic            brku_q,
    output logic [2:0]      cause_q,
    output logic [1:0]      prv_q,
    output logic [XLEN-1:0] dpc_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= 1'b0;
            brkm_q <= 1'b0;
            brku_q <= 1'b0;
        end else if (ctl_wr) begin
            step_q <= ctl_step_i;
            brkm_q <= ctl_brkm_i;
            brku_q <= ctl_brku_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= CAUSE_NONE;
            prv_q   <= PRV_MACHINE;
            dpc_q   <= '0;
        end else if (capture) begin
            cause_q <= cause_i;
            prv_q   <= prv_i;
            dpc_q   <= pc_i;
        end
    end
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
    import dbg_mode_pkg::*;
#(
    parameter int               XLEN      = 32,
    parameter logic [XLEN-1:0]  ROM_ENTRY = 32'h0000_0800,
    parameter logic [XLEN-1:0]  ROM_EXC   = 32'h0000_0808
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halt_req_i,
    input  logic            brk_i,
    input  logic            ret_i,
    input  logic            wfi_i,
    input  logic            exc_i,
    input  logic            retire_i,
    input  logic            irq_pend_i,
    input  logic [1:0]      cur_prv_i,
    input  logic [XLEN-1:0] inst_pc_i,
    input  logic [XLEN-1:0] next_pc_i,
    input  logic            ctl_we_i,
    input  logic            ctl_step_i,
    input  logic            ctl_brkm_i,
    input  logic            ctl_brku_i,
    output logic            in_dbg_o,
    output logic            sleep_o,
    output logic            redir_o,
    output logic [XLEN-1:0] redir_pc_o,
    output logic            irq_take_o,
    output logic            wfi_nop_o,
    output logic            illegal_o,
    output logic            brk_exc_o,
    output logic            trap_wr_o,
    output logic [2:0]      cause_o,
    output logic [1:0]      saved_prv_o,
    output logic [XLEN-1:0] dpc_o
);
    dbg_state_e state_q, state_d;

    logic            brk_route;
    logic            enter;
    logic [2:0]      ent_cause;
    logic            use_inst_pc;
    logic            step_q, brkm_q, brku_q;
    logic            ctl_wr;
    logic [XLEN-1:0] cap_pc;
    logic            dbg_st;
    logic            exec_st;

    assign dbg_st  = (state_q == ST_DEBUG);
    assign exec_st = (state_q == ST_RUN) || (state_q == ST_STEP);
    assign ctl_wr  = ctl_we_i && dbg_st;
    assign cap_pc  = use_inst_pc ? inst_pc_i : next_pc_i;

    dbg_entry_arb u_arb (
        .state       (state_q),
        .halt_req_i  (halt_req_i),
        .brk_i       (brk_i),
        .exc_i       (exc_i),
        .retire_i    (retire_i),
        .cur_prv_i   (cur_prv_i),
        .brkm        (brkm_q),
        .brku        (brku_q),
        .brk_route   (brk_route),
        .enter       (enter),
        .cause       (ent_cause),
        .use_inst_pc (use_inst_pc)
    );

    dbg_csr_file #(.XLEN(XLEN)) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_step_i (ctl_step_i),
        .ctl_brkm_i (ctl_brkm_i),
        .ctl_brku_i (ctl_brku_i),
        .capture    (enter),
        .cause_i    (ent_cause),
        .prv_i      (cur_prv_i),
        .pc_i       (cap_pc),
        .step_q     (step_q),
        .brkm_q     (brkm_q),
        .brku_q     (brku_q),
        .cause_q    (cause_o),
        .prv_q      (saved_prv_o),
        .dpc_q      (dpc_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (enter)
                    state_d = ST_DEBUG;
                else if (wfi_i && !exc_i && !irq_pend_i)
                    state_d = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (enter)           state_d = ST_DEBUG;
                else if (irq_pend_i) state_d = ST_RUN;
            end
            ST_DEBUG: begin
                if (!exc_i && !brk_i && ret_i)
                    state_d = step_q ? ST_STEP : ST_RUN;
            end
            ST_STEP: begin
                if (enter) state_d = ST_DEBUG;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // Output logic
    always_comb begin
        redir_o    = 1'b0;
        redir_pc_o = ROM_ENTRY;
        wfi_nop_o  = 1'b0;
        illegal_o  = 1'b0;
        brk_exc_o  = 1'b0;
        trap_wr_o  = 1'b0;
        irq_take_o = 1'b0;
        unique case (state_q)
            ST_DEBUG: begin
                if (exc_i) begin
                    redir_o    = 1'b1;
                    redir_pc_o = ROM_EXC;
                end else if (brk_i) begin
                    redir_o    = 1'b1;
                    redir_pc_o = ROM_ENTRY;
                end else if (ret_i) begin
                    redir_o    = 1'b1;
                    redir_pc_o = dpc_o;
                end else if (wfi_i) begin
                    wfi_nop_o  = 1'b1;
                end
            end
            ST_RUN, ST_SLEEP, ST_STEP: begin
                if (enter) begin
                    redir_o    = 1'b1;
                    redir_pc_o = ROM_ENTRY;
                end
                trap_wr_o  = exc_i;
                illegal_o  = ret_i && exec_st;
                brk_exc_o  = exec_st && brk_i && !brk_route && !exc_i;
                irq_take_o = irq_pend_i && !enter;
            end
            default: ;
        endcase
    end

    assign in_dbg_o = dbg_st;
    assign sleep_o  = (state_q == ST_SLEEP);

endmodule

// File: rtl/dbg_mode_chk.sv
module dbg_mode_chk #(
    parameter int               XLEN      = 32,
    parameter logic [XLEN-1:0]  ROM_ENTRY = 32'h0000_0800
) (
    input logic            clk,
    input logic            rst_n,
    input logic            halt_req_i,
    input logic            brk_i,
    input logic            ret_i,
    input logic            wfi_i,
    input logic            exc_i,
    input logic            retire_i,
    input logic            in_dbg_o,
    input logic            sleep_o,
    input logic            redir_o,
    input logic [XLEN-1:0] redir_pc_o,
    input logic            irq_take_o,
    input logic            illegal_o,
    input logic            trap_wr_o,
    input logic [XLEN-1:0] dpc_o
);
    a_r1_enter_next: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_o && redir_pc_o == ROM_ENTRY && !in_dbg_o) |=> in_dbg_o);

    a_r3_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        in_dbg_o |-> !irq_take_o);

    a_r3_entry_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_o && !in_dbg_o) |-> !irq_take_o);

    a_r4_wfi_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dbg_o && wfi_i && !exc_i && !ret_i && !brk_i) |=> (in_dbg_o && !sleep_o));

    a_r5_dret_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_dbg_o && !sleep_o && ret_i && !halt_req_i && !brk_i && !retire_i && !wfi_i)
        |=> !in_dbg_o);

    a_r6_reenter_keeps_dpc: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dbg_o && brk_i && !exc_i) |=> (in_dbg_o && $stable(dpc_o)));

    a_r10_no_trap_in_dbg: assert property (@(posedge clk) disable iff (!rst_n)
        in_dbg_o |-> !trap_wr_o);

    a_r10_exc_keeps_dbg: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dbg_o && exc_i) |=> in_dbg_o);

    a_r5_illegal_no_redir: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !in_dbg_o);
endmodule

bind dbg_mode_ctrl dbg_mode_chk #(.XLEN(XLEN), .ROM_ENTRY(ROM_ENTRY)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_req_i (halt_req_i),
    .brk_i      (brk_i),
    .ret_i      (ret_i),
    .wfi_i      (wfi_i),
    .exc_i      (exc_i),
    .retire_i   (retire_i),
    .in_dbg_o   (in_dbg_o),
    .sleep_o    (sleep_o),
    .redir_o    (redir_o),
    .redir_pc_o (redir_pc_o),
    .irq_take_o (irq_take_o),
    .illegal_o  (illegal_o),
    .trap_wr_o  (trap_wr_o),
    .dpc_o      (dpc_o)
);

// File: tb/sim_dbg_mode_ctrl.sv
module sim_dbg_mode_ctrl;
    localparam int          XLEN  = 32;
    localparam logic [31:0] ENTRY = 32'h0000_0800;
    localparam logic [31:0] EXCA  = 32'h0000_0808;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_req_i = 0, brk_i = 0, ret_i = 0, wfi_i = 0, exc_i = 0, retire_i = 0, irq_pend_i = 0;
    logic [1:0] cur_prv_i = 2'd3;
    logic [31:0] inst_pc_i = '0, next_pc_i = '0;
    logic ctl_we_i = 0, ctl_step_i = 0, ctl_brkm_i = 0, ctl_brku_i = 0;
    logic in_dbg_o, sleep_o, redir_o, irq_take_o, wfi_nop_o, illegal_o, brk_exc_o, trap_wr_o;
    logic [31:0] redir_pc_o, dpc_o;
    logic [2:0] cause_o;
    logic [1:0] saved_prv_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dbg_mode_ctrl #(.XLEN(XLEN), .ROM_ENTRY(ENTRY), .ROM_EXC(EXCA)) u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        halt_req_i = 0; brk_i = 0; ret_i = 0; wfi_i = 0; exc_i = 0; retire_i = 0;
        irq_pend_i = 0; ctl_we_i = 0;
    endtask

    // Inputs already set after a negedge: wait to mid-low, let the edge pass,
    // then clear inputs at the following negedge.
    task automatic settle();  #5; endtask
    task automatic advance(); @(negedge clk); clear_in(); #1; endtask

    task automatic go_halt(input logic [31:0] npc);
        @(negedge clk); halt_req_i = 1; next_pc_i = npc; advance();
    endtask

    task automatic go_ret();
        @(negedge clk); ret_i = 1; advance();
    endtask

    task automatic ctl_write(input logic s, input logic m, input logic u);
        @(negedge clk); ctl_we_i = 1; ctl_step_i = s; ctl_brkm_i = m; ctl_brku_i = u; advance();
    endtask

    task automatic t_reset();
        chk("R1 reset in_dbg", in_dbg_o, 0);
        chk("R2 reset sleep", sleep_o, 0);
        chk("R1 reset cause", cause_o, 0);
        chk("R8 reset prv", saved_prv_o, 3);
        chk("R1 reset dpc", dpc_o, 0);
    endtask

    task automatic t_halt_vs_irq();
        @(negedge clk); cur_prv_i = 3; next_pc_i = 32'h100; halt_req_i = 1; irq_pend_i = 1;
        settle();
        chk("R1 redir", redir_o, 1);
        chk("R1 redir pc", redir_pc_o, ENTRY);
        chk("R3 entry wins irq", irq_take_o, 0);
        advance();
        chk("R1 in_dbg", in_dbg_o, 1);
        chk("R1 dpc", dpc_o, 32'h100);
        chk("R1 cause", cause_o, 3);
        chk("R1 prv", saved_prv_o, 3);
    endtask

    task automatic t_in_debug();
        @(negedge clk); irq_pend_i = 1; halt_req_i = 1; settle();
        chk("R3 irq masked", irq_take_o, 0);
        chk("R1 no re-entry on request", redir_o, 0);
        advance();
        @(negedge clk); wfi_i = 1; settle();
        chk("R4 wfi nop", wfi_nop_o, 1);
        chk("R4 no redir", redir_o, 0);
        advance();
        chk("R4 stays debug", in_dbg_o, 1);
        chk("R4 no sleep", sleep_o, 0);
        @(negedge clk); brk_i = 1; inst_pc_i = 32'h804; settle();
        chk("R6 redir", redir_o, 1);
        chk("R6 redir pc", redir_pc_o, ENTRY);
        advance();
        chk("R6 stays", in_dbg_o, 1);
        chk("R6 dpc kept", dpc_o, 32'h100);
        chk("R6 cause kept", cause_o, 3);
        @(negedge clk); exc_i = 1; settle();
        chk("R10 no trap write", trap_wr_o, 0);
        chk("R10 redir", redir_o, 1);
        chk("R10 redir pc", redir_pc_o, EXCA);
        advance();
        chk("R10 stays", in_dbg_o, 1);
    endtask

    task automatic t_dret();
        @(negedge clk); ret_i = 1; settle();
        chk("R8 redir", redir_o, 1);
        chk("R8 redir pc", redir_pc_o, dpc_o);
        chk("R8 prv", saved_prv_o, 3);
        advance();
        chk("R8 left debug", in_dbg_o, 0);
    endtask

    task automatic t_outside();
        @(negedge clk); ret_i = 1; settle();
        chk("R5 illegal", illegal_o, 1);
        chk("R5 no redir", redir_o, 0);
        advance();
        chk("R5 state kept", in_dbg_o, 0);
        chk("R5 no sleep", sleep_o, 0);
        @(negedge clk); exc_i = 1; settle();
        chk("R10 trap write", trap_wr_o, 1);
        advance();
    endtask

    task automatic t_brk_routing();
        // machine-mode breakpoint routed (brkm set earlier)
        @(negedge clk); cur_prv_i = 3; brk_i = 1; inst_pc_i = 32'h200; next_pc_i = 32'h204; settle();
        chk("R7 redir", redir_o, 1);
        chk("R7 no exc", brk_exc_o, 0);
        advance();
        chk("R7 in_dbg", in_dbg_o, 1);
        chk("R7 cause", cause_o, 1);
        chk("R7 dpc", dpc_o, 32'h200);
        go_ret();
        // user-mode breakpoint not routed
        @(negedge clk); cur_prv_i = 0; brk_i = 1; settle();
        chk("R7 user exc", brk_exc_o, 1);
        chk("R7 user no redir", redir_o, 0);
        advance();
        chk("R7 user stays out", in_dbg_o, 0);
        cur_prv_i = 3;
    endtask

    task automatic t_ctl_ignored();
        ctl_write(1, 1, 1);
        go_halt(32'h180);
        chk("R11 entered", in_dbg_o, 1);
        go_ret();
        @(negedge clk); retire_i = 1; next_pc_i = 32'h184; settle();
        chk("R11 step not armed", redir_o, 0);
        advance();
        chk("R11 still running", in_dbg_o, 0);
        @(negedge clk); cur_prv_i = 0; brk_i = 1; settle();
        chk("R11 brku not set", brk_exc_o, 1);
        advance();
        cur_prv_i = 3;
    endtask

    task automatic t_step();
        go_halt(32'h2F0);
        ctl_write(1, 1, 1);
        go_ret();
        chk("R9 out after dret", in_dbg_o, 0);
        @(negedge clk); settle();
        chk("R9 no entry before retire", redir_o, 0);
        advance();
        @(negedge clk); retire_i = 1; next_pc_i = 32'h300; settle();
        chk("R9 redir", redir_o, 1);
        chk("R9 redir pc", redir_pc_o, ENTRY);
        advance();
        chk("R9 in_dbg", in_dbg_o, 1);
        chk("R9 cause", cause_o, 4);
        chk("R9 dpc", dpc_o, 32'h300);
        ctl_write(0, 1, 1);
        go_ret();
    endtask

    task automatic t_user_brk();
        @(negedge clk); cur_prv_i = 0; brk_i = 1; inst_pc_i = 32'h400; settle();
        chk("R7 user routed", redir_o, 1);
        advance();
        chk("R7 user cause", cause_o, 1);
        chk("R8 prv saved user", saved_prv_o, 0);
        go_ret();
        cur_prv_i = 3;
    endtask

    task automatic t_priority();
        @(negedge clk); halt_req_i = 1; brk_i = 1; inst_pc_i = 32'h500; next_pc_i = 32'h504; settle();
        chk("R12 redir", redir_o, 1);
        advance();
        chk("R12 cause brk", cause_o, 1);
        chk("R12 dpc brk", dpc_o, 32'h500);
        go_ret();
    endtask

    task automatic t_sleep();
        @(negedge clk); wfi_i = 1; advance();
        chk("R2 sleeping", sleep_o, 1);
        @(negedge clk); halt_req_i = 1; next_pc_i = 32'h600; irq_pend_i = 1; settle();
        chk("R2 wake redir", redir_o, 1);
        chk("R3 wake entry wins", irq_take_o, 0);
        advance();
        chk("R2 wake in_dbg", in_dbg_o, 1);
        chk("R2 wake not sleep", sleep_o, 0);
        chk("R2 wake dpc", dpc_o, 32'h600);
        go_ret();
        @(negedge clk); wfi_i = 1; advance();
        chk("R2 sleep again", sleep_o, 1);
        @(negedge clk); irq_pend_i = 1; settle();
        chk("R2 irq take", irq_take_o, 1);
        advance();
        chk("R2 irq wake", sleep_o, 0);
        chk("R2 irq not debug", in_dbg_o, 0);
    endtask

    initial begin
        #25 rst_n = 1;
        @(negedge clk); #1;
        t_reset();
        t_halt_vs_irq();
        t_in_debug();
        ctl_write(0, 1, 0);
        t_dret();
        t_outside();
        t_brk_routing();
        t_ctl_ignored();
        t_step();
        t_user_brk();
        t_priority();
        t_sleep();
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule